// File: doc/BRIEF.md
# Uncorrectable Error Capture and Header Log

This block keeps the uncorrectable error state of a serial-link endpoint. Error detectors present a strobe, a 32-bit vector with one bit per error class, and the first 32-bit word of the header of the packet involved. Each asserted vector bit sets a status bit. While the status register is entirely clear, the log is armed. The first error that arrives in that state records the index of its bit in a first-error pointer and stores the header word. Both then stay frozen until software has cleared every status bit.

Software uses a small register bus with a one-cycle read latency. Status bits are cleared by writing ones. The control word holds two end-to-end CRC enable bits, two fixed capability flags and the pointer. Enables, pointer and header log are sticky: a warm reset clears only the status register, and only the cold reset clears the sticky state.

Top module: `uerr_capture`

## Requirements
- R1: The control word (address 1) has check-enable at bit 8, check-capable at bit 7, generate-enable at bit 6, generate-capable at bit 5 and the first-error pointer at bits 4:0. Bits 31:9 read as 0.
- R2: After cold reset, status reads 0, the header log reads 0, both enable bits and the pointer are 0, and both capability bits are 1 (control reads 0x000000A0).
- R3: Writes to the control word change only bits 8 and 6. The capability flags and the pointer ignore writes.
- R4: Status (address 0) sets every bit that is high in the error vector when the strobe is high. A written 1 clears the bit and a written 0 leaves it unchanged. A set and a clear of the same bit in the same cycle leave the bit set.
- R5: When all status bits are 0 and an error arrives, the pointer takes the lowest-numbered bit that is high in the vector.
- R6: In that same capture, the header log (address 2) takes the header word presented in that cycle.
- R7: While any status bit is set, new errors still set their status bits but change neither the pointer nor the header log.
- R8: The log re-arms only when every status bit is 0. Clearing only the bit that caused the capture keeps it locked.
- R9: Warm reset clears the status register and ignores errors during its cycle. It keeps the enables, the pointer and the header log. Cold reset clears everything.
- R10: The header log is read-only: writes to address 2 have no effect.
- R11: A read request returns data with rvalid high in the next cycle. Address 3 reads as 0.
- R12: chk_en_o and gen_en_o follow control bits 8 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| warm_rst_ni | input | 1 | Warm reset, active low, synchronous |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Word address: 0 status, 1 control, 2 header log |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| err_valid_i | input | 1 | Error strobe |
| err_vec_i | input | 32 | Error classes asserted this cycle |
| err_hdr_i | input | 32 | First header word of the packet in error |
| chk_en_o | output | 1 | End-to-end CRC check enable |
| gen_en_o | output | 1 | End-to-end CRC generate enable |

## Verification
An error strobe or a register write takes effect at the next rising edge. A read request is answered with rvalid and data one edge later, so status, pointer and log changes can be read back from the cycle that follows the stimulus. The driver raises each request at a falling edge and queues the expected word. The monitor pops the queue at the next falling edge, when rvalid is due, and it flags any rvalid that has no queued word.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 2;
  localparam int unsigned PTR_W = $clog2(DW);

  localparam logic [AW-1:0] A_STATUS = 2'd0;
  localparam logic [AW-1:0] A_CTRL   = 2'd1;
  localparam logic [AW-1:0] A_HDR    = 2'd2;

  localparam int unsigned B_CHK_EN  = 8;
  localparam int unsigned B_CHK_CAP = 7;
  localparam int unsigned B_GEN_EN  = 6;
  localparam int unsigned B_GEN_CAP = 5;

  function automatic logic [PTR_W-1:0] lowest_set(input logic [DW-1:0] v);
    logic [PTR_W-1:0] idx;
    idx = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) idx = PTR_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/uerr_status.sv
module uerr_status
  import uerr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] sts_o
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           bit_q <= 1'b0;
      else if (!warm_rst_ni) bit_q <= 1'b0;
      else if (set_i[g])     bit_q <= 1'b1;  // set beats clear
      else if (clr_i[g])     bit_q <= 1'b0;
    end
    assign sts_o[g] = bit_q;
  end
endmodule

// File: rtl/uerr_first_log.sv
module uerr_first_log
  import uerr_pkg::*;
#(
  parameter int unsigned HDR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             warm_rst_ni,
  input  logic             arm_i,
  input  logic             err_valid_i,
  input  logic [DW-1:0]    err_vec_i,
  input  logic [HDR_W-1:0] err_hdr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [HDR_W-1:0] hdr_o
);
  logic             cap;
  logic [PTR_W-1:0] ptr_q;
  logic [HDR_W-1:0] hdr_q;

  assign cap = arm_i && err_valid_i && (|err_vec_i) && warm_rst_ni;

  // sticky: cold reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      hdr_q <= '0;
    end else if (cap) begin
      ptr_q <= lowest_set(err_vec_i);
      hdr_q <= err_hdr_i;
    end
  end

  assign ptr_o = ptr_q;
  assign hdr_o = hdr_q;
endmodule

// File: rtl/uerr_regbus.sv
module uerr_regbus
  import uerr_pkg::*;
#(
  parameter bit CHK_CAP = 1'b1,
  parameter bit GEN_CAP = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    sts_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [DW-1:0]    hdr_i,
  output logic [DW-1:0]    clr_o,
  output logic             chk_en_o,
  output logic             gen_en_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o
);
  logic          chk_en_q, gen_en_q;
  logic          wr, rd;
  logic [DW-1:0] ctrl_word, rmux;
  logic [DW-1:0] rdata_q;
  logic          rvalid_q;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign clr_o = (wr && addr_i == A_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_en_q <= 1'b0;
      gen_en_q <= 1'b0;
    end else if (wr && addr_i == A_CTRL) begin
      chk_en_q <= wdata_i[B_CHK_EN];
      gen_en_q <= wdata_i[B_GEN_EN];
    end
  end

  always_comb begin
    ctrl_word            = '0;
    ctrl_word[PTR_W-1:0] = ptr_i;
    ctrl_word[B_CHK_EN]  = chk_en_q;
    ctrl_word[B_CHK_CAP] = CHK_CAP;
    ctrl_word[B_GEN_EN]  = gen_en_q;
    ctrl_word[B_GEN_CAP] = GEN_CAP;
  end

  always_comb begin
    unique case (addr_i)
      A_STATUS: rmux = sts_i;
      A_CTRL:   rmux = ctrl_word;
      A_HDR:    rmux = hdr_i;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rmux;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign chk_en_o = chk_en_q;
  assign gen_en_o = gen_en_q;
endmodule

// File: rtl/uerr_capture.sv
module uerr_capture
  import uerr_pkg::*;
#(
  parameter bit CHK_CAP = 1'b1,
  parameter bit GEN_CAP = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  input  logic          err_valid_i,
  input  logic [DW-1:0] err_vec_i,
  input  logic [DW-1:0] err_hdr_i,
  output logic          chk_en_o,
  output logic          gen_en_o
);
  logic [DW-1:0]    sts_q;
  logic [DW-1:0]    sts_set;
  logic [DW-1:0]    sts_clr;
  logic [PTR_W-1:0] first_ptr;
  logic [DW-1:0]    hdr_log;
  logic             armed;

  assign sts_set = err_valid_i ? err_vec_i : '0;
  assign armed   = (sts_q == '0);

  uerr_status u_sts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_ni (warm_rst_ni),
    .set_i       (sts_set),
    .clr_i       (sts_clr),
    .sts_o       (sts_q)
  );

  uerr_first_log #(.HDR_W(DW)) u_log (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_rst_ni (warm_rst_ni),
    .arm_i       (armed),
    .err_valid_i (err_valid_i),
    .err_vec_i   (err_vec_i),
    .err_hdr_i   (err_hdr_i),
    .ptr_o       (first_ptr),
    .hdr_o       (hdr_log)
  );

  uerr_regbus #(.CHK_CAP(CHK_CAP), .GEN_CAP(GEN_CAP)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .sts_i    (sts_q),
    .ptr_i    (first_ptr),
    .hdr_i    (hdr_log),
    .clr_o    (sts_clr),
    .chk_en_o (chk_en_o),
    .gen_en_o (gen_en_o),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid_o)
  );
endmodule

// File: rtl/uerr_capture_chk.sv
module uerr_capture_chk
  import uerr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             warm_rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic [DW-1:0]    rdata_o,
  input logic             rvalid_o,
  input logic             err_valid_i,
  input logic [DW-1:0]    err_vec_i,
  input logic [DW-1:0]    err_hdr_i,
  input logic [DW-1:0]    sts,
  input logic [PTR_W-1:0] ptr,
  input logic [DW-1:0]    hdr
);
  p_ctrl_layout_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i) == A_CTRL) |->
      (rdata_o[DW-1:9] == '0 && rdata_o[PTR_W-1:0] == $past(ptr)));

  p_sts_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_valid_i && warm_rst_ni) |=> ((sts & $past(err_vec_i)) == $past(err_vec_i)));

  p_sts_w1c_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_STATUS && warm_rst_ni && !err_valid_i) |=>
      (sts == ($past(sts) & ~$past(wdata_i))));

  p_ptr_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts == '0 && err_valid_i && (|err_vec_i) && warm_rst_ni) |=>
      (ptr == lowest_set($past(err_vec_i))));

  p_hdr_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts == '0 && err_valid_i && (|err_vec_i) && warm_rst_ni) |=>
      (hdr == $past(err_hdr_i)));

  p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts != '0) |=> ($stable(ptr) && $stable(hdr)));

  p_warm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm_rst_ni |=> (sts == '0 && $stable(ptr) && $stable(hdr)));

  p_hdr_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_HDR && !err_valid_i) |=> $stable(hdr));

  p_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);

  p_no_rvalid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

bind uerr_capture uerr_capture_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .warm_rst_ni (warm_rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .err_valid_i (err_valid_i),
  .err_vec_i   (err_vec_i),
  .err_hdr_i   (err_hdr_i),
  .sts         (sts_q),
  .ptr         (first_ptr),
  .hdr         (hdr_log)
);

// File: tb/sim_uerr_capture.sv
`timescale 1ns/1ps
module sim_uerr_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm_n = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        ev = 1'b0;
  logic [31:0] evec = '0;
  logic [31:0] ehdr = '0;
  logic        chk_en, gen_en;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  uerr_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_ni(warm_n),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid),
    .err_valid_i(ev), .err_vec_i(evec), .err_hdr_i(ehdr),
    .chk_en_o(chk_en), .gen_en_o(gen_en)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: compares read returns against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) check(rdata, 32'hxxxxxxxx, "R11 unexpected rvalid");
      else check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic err(input logic [31:0] v, input logic [31:0] h);
    ev = 1'b1; evec = v; ehdr = h;
    @(negedge clk);
    ev = 1'b0; evec = '0; ehdr = '0;
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    check(32'(exp_q.size()), 32'd0, "R11 missing read return");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    rd(2'd0, 32'h0, "R2 status after cold reset");
    rd(2'd1, 32'h000000A0, "R2 R1 control after cold reset");
    rd(2'd2, 32'h0, "R2 header after cold reset");
    check({30'd0, chk_en, gen_en}, 32'd0, "R12 pins after reset");
    // R3 writable enables only
    wr(2'd1, 32'hFFFFFFFF);
    rd(2'd1, 32'h000001E0, "R3 R1 control all-ones write");
    check({30'd0, chk_en, gen_en}, 32'd3, "R12 pins both set");
    wr(2'd1, 32'h00000100);
    rd(2'd1, 32'h000001A0, "R3 check only");
    check({30'd0, chk_en, gen_en}, 32'd2, "R12 pins check only");
    // R10 header read-only
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, 32'h0, "R10 header ignores write");
    // R4 R5 R6 first capture, two bits same cycle
    err(32'h00000C00, 32'hDEADBEEF);
    rd(2'd0, 32'h00000C00, "R4 status set");
    rd(2'd1, 32'h000001AA, "R5 pointer lowest bit 10");
    rd(2'd2, 32'hDEADBEEF, "R6 header captured");
    // R7 locked
    err(32'h00000001, 32'h12345678);
    rd(2'd0, 32'h00000C01, "R7 status still sets while locked");
    rd(2'd1, 32'h000001AA, "R7 pointer held");
    rd(2'd2, 32'hDEADBEEF, "R7 header held");
    // R8 clear causing bit only
    wr(2'd0, 32'h00000400);
    rd(2'd0, 32'h00000801, "R4 w1c clears bit 10");
    wr(2'd0, 32'h00000000);
    rd(2'd0, 32'h00000801, "R4 write zero no effect");
    err(32'h00000002, 32'h00001111);
    rd(2'd1, 32'h000001AA, "R8 still locked after causing bit cleared");
    rd(2'd2, 32'hDEADBEEF, "R8 header still locked");
    // R4 set wins over same-cycle clear
    req = 1'b1; we = 1'b1; addr = 2'd0; wdata = 32'h2;
    ev = 1'b1; evec = 32'h2; ehdr = 32'h2222;
    @(negedge clk);
    req = 1'b0; we = 1'b0; ev = 1'b0; evec = '0; ehdr = '0;
    rd(2'd0, 32'h00000803, "R4 set beats clear");
    wr(2'd0, 32'h00000803);
    rd(2'd0, 32'h0, "R4 all cleared");
    rd(2'd1, 32'h000001AA, "R8 pointer kept after re-arm");
    // empty strobe does nothing
    err(32'h0, 32'h99999999);
    rd(2'd2, 32'hDEADBEEF, "R6 empty vector no capture");
    // R5 R6 new capture at top bit
    err(32'h80000000, 32'hCAFEF00D);
    rd(2'd1, 32'h000001BF, "R5 pointer bit 31");
    rd(2'd2, 32'hCAFEF00D, "R6 header recaptured");
    // R9 warm reset; error during warm is ignored
    warm_n = 1'b0; ev = 1'b1; evec = 32'h1; ehdr = 32'h5555;
    @(negedge clk);
    warm_n = 1'b1; ev = 1'b0; evec = '0; ehdr = '0;
    rd(2'd0, 32'h0, "R9 warm clears status");
    rd(2'd1, 32'h000001BF, "R9 warm keeps control and pointer");
    rd(2'd2, 32'hCAFEF00D, "R9 warm keeps header");
    check({30'd0, chk_en, gen_en}, 32'd2, "R12 pins kept over warm");
    // R8 armed after warm clear
    err(32'h00000030, 32'h0000A5A5);
    rd(2'd1, 32'h000001A4, "R8 re-armed pointer bit 4");
    rd(2'd2, 32'h0000A5A5, "R8 re-armed header");
    rd(2'd3, 32'h0, "R11 unmapped read");
    drain();
    // R9 cold reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, 32'h0, "R9 cold clears status");
    rd(2'd1, 32'h000000A0, "R9 cold clears control");
    rd(2'd2, 32'h0, "R9 cold clears header");
    check({30'd0, chk_en, gen_en}, 32'd0, "R12 pins after cold");
    drain();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule